// File: doc/BRIEF.md
# Frequent-Row Activation Tracker

This block sits beside one DRAM bank and watches the stream of row activations to find rows that are opened often enough to disturb their neighbours. It keeps a small associative table in which each entry pairs a row address with an estimated activation count, plus one spillover counter. Together these implement the frequent-items summary: a row that is activated more than a fixed share of the window is always present in the table, and its estimated count never falls below its true count.

Each time an entry's estimated count reaches a multiple of the threshold, the block emits a one-cycle refresh request. The request carries the aggressor row and the clamped span of neighbour rows that should be refreshed. A periodic window-clear pulse forgets everything. Activations arrive over a valid/ready pair, and each update takes two clock cycles, which fits inside one activate-to-activate interval. Issuing the refresh commands is left to the memory controller. The reset is asynchronous and active low, and is expected to be released synchronously to `clk`.

Top module: `frow_tracker`

## Requirements
- R1: After reset or after a window clear (`win_clr` high at an edge), every entry is empty, the spillover count is zero, `act_ready` is high and `rfsh_valid` is low.
- R2: An activation whose row matches a valid entry increases that entry's count by one.
- R3: On a miss, an entry whose count equals the spillover count is taken over by the new row. Its count becomes spillover plus one, so the old count is carried over and not cleared. Empty entries hold count zero and are taken while the spillover count is zero.
- R4: On a miss where no eligible entry's count equals the spillover count, the table is unchanged and the spillover count increases by one, saturating at its maximum.
- R5: When an update brings an entry's count to `THRESH`, a refresh request for that row is raised. The count wraps to zero and the entry's overflow bit is set. A further request is raised each time the count reaches `THRESH` again.
- R6: An entry whose overflow bit is set is never taken over, and its overflow bit and key hold until the next window clear.
- R7: If several entries are eligible for takeover, the lowest-index one is taken.
- R8: `rfsh_first` equals max(row − `RADIUS`, 0) and `rfsh_last` equals min(row + `RADIUS`, 2^`ROW_W` − 1), where row is `rfsh_row`.
- R9: An activation is accepted at an edge where `act_valid` and `act_ready` are both high. `act_ready` is low in the following cycle. Any refresh caused by that activation appears on `rfsh_valid` for exactly the one cycle after the next edge.
- R10: When `win_clr` and an accepted activation share an edge, the clear is applied first and the activation is then counted against the empty table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_clr | input | 1 | Window clear pulse: empties the table and zeroes the spillover count |
| act_valid | input | 1 | Activation present |
| act_ready | output | 1 | Tracker can accept an activation |
| act_row | input | ROW_W | Activated row address |
| rfsh_valid | output | 1 | One-cycle refresh request |
| rfsh_row | output | ROW_W | Aggressor row of the request |
| rfsh_first | output | ROW_W | Lowest neighbour row to refresh |
| rfsh_last | output | ROW_W | Highest neighbour row to refresh |

## Verification
An activation accepted at edge N makes `act_ready` fall for the cycle after edge N. Any refresh it causes is registered at edge N+1 and is visible until edge N+2. The driver records, for every expected refresh, the cycle number of edge N+1. The monitor samples on falling edges and compares the row, the span and the arrival cycle, so an early or late pulse fails even when the row is correct. Window clears are sent only after the pending update has retired, except in the one test that deliberately makes a clear coincide with an activation.

// File: rtl/frt_pkg.sv
package frt_pkg;
  // kind of table update performed for one activation
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_HIT   = 2'd1,
    UPD_TAKE  = 2'd2,
    UPD_SPILL = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/frt_key_match.sv
module frt_key_match #(
  parameter int ENTRIES = 81,
  parameter int ROW_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENTRIES-1:0][ROW_W-1:0] keys,
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ROW_W-1:0]              row,
  output logic                          any_hit,
  output logic [IDX_W-1:0]              hit_idx
);
  logic [ENTRIES-1:0] hit_vec;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = vld[g] && (keys[g] == row);
    end
  endgenerate

  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // R2: no two valid entries ever hold the same row
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
endmodule

// File: rtl/frt_spill_pick.sv
module frt_spill_pick #(
  parameter int ENTRIES = 81,
  parameter int CNT_W   = 14,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][CNT_W-1:0] cnts,
  input  logic [ENTRIES-1:0]            ovf,
  input  logic [CNT_W-1:0]              spill,
  output logic                          take_ok,
  output logic [IDX_W-1:0]              take_idx
);
  logic [ENTRIES-1:0] cand;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cand
      assign cand[g] = !ovf[g] && (cnts[g] == spill);
    end
  endgenerate

  // lowest index wins
  always_comb begin
    take_ok  = 1'b0;
    take_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        take_ok  = 1'b1;
        take_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/frt_victim_span.sv
module frt_victim_span #(
  parameter int ROW_W  = 16,
  parameter int RADIUS = 1
) (
  input  logic [ROW_W-1:0] row,
  output logic [ROW_W-1:0] first,
  output logic [ROW_W-1:0] last
);
  localparam logic [ROW_W:0] RAD_W = (ROW_W+1)'(RADIUS);
  localparam logic [ROW_W:0] TOP_W = {1'b0, {ROW_W{1'b1}}};

  logic [ROW_W:0] wide_row;
  logic [ROW_W:0] hi_sum;

  always_comb begin
    wide_row = {1'b0, row};
    hi_sum   = wide_row + RAD_W;
    if (wide_row < RAD_W) first = '0;
    else                  first = ROW_W'(wide_row - RAD_W);
    if (hi_sum > TOP_W)   last  = {ROW_W{1'b1}};
    else                  last  = hi_sum[ROW_W-1:0];
  end
endmodule

// File: rtl/frow_tracker.sv
module frow_tracker #(
  parameter int ROW_W   = 16,
  parameter int ENTRIES = 81,
  parameter int CNT_W   = 14,
  parameter int THRESH  = 8333,
  parameter int RADIUS  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_clr,
  input  logic             act_valid,
  output logic             act_ready,
  input  logic [ROW_W-1:0] act_row,
  output logic             rfsh_valid,
  output logic [ROW_W-1:0] rfsh_row,
  output logic [ROW_W-1:0] rfsh_first,
  output logic [ROW_W-1:0] rfsh_last
);
  import frt_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [CNT_W:0]   THR_W     = (CNT_W+1)'(THRESH);
  localparam logic [CNT_W-1:0] SPILL_MAX = {CNT_W{1'b1}};

  // table state
  logic [ENTRIES-1:0][ROW_W-1:0] key_q, key_n;
  logic [ENTRIES-1:0][CNT_W-1:0] cnt_q, cnt_n;
  logic [ENTRIES-1:0]            ovf_q, ovf_n;
  logic [ENTRIES-1:0]            vld_q, vld_n;
  logic [CNT_W-1:0]              spill_q, spill_n;
  // pending activation
  logic                          stg_vld_q, stg_vld_n;
  logic [ROW_W-1:0]              stg_row_q, stg_row_n;
  // refresh request
  logic                          rf_vld_q, rf_vld_n;
  logic [ROW_W-1:0]              rf_row_q, rf_row_n;

  logic             accept;
  logic             any_hit, take_ok;
  logic [IDX_W-1:0] hit_idx, take_idx, upd_idx;
  upd_kind_e        kind;
  logic [CNT_W:0]   new_cnt;
  logic             at_thr;

  assign act_ready = !stg_vld_q;
  assign accept    = act_valid && act_ready;

  frt_key_match #(.ENTRIES(ENTRIES), .ROW_W(ROW_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .keys    (key_q),
    .vld     (vld_q),
    .row     (stg_row_q),
    .any_hit (any_hit),
    .hit_idx (hit_idx)
  );

  frt_spill_pick #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_pick (
    .cnts     (cnt_q),
    .ovf      (ovf_q),
    .spill    (spill_q),
    .take_ok  (take_ok),
    .take_idx (take_idx)
  );

  // classify the pending update
  always_comb begin
    if (!stg_vld_q || win_clr) kind = UPD_NONE;
    else if (any_hit)          kind = UPD_HIT;
    else if (take_ok)          kind = UPD_TAKE;
    else                       kind = UPD_SPILL;
    upd_idx = (kind == UPD_HIT) ? hit_idx : take_idx;
    if (kind == UPD_HIT) new_cnt = {1'b0, cnt_q[hit_idx]} + 1'b1;
    else                 new_cnt = {1'b0, spill_q} + 1'b1;
    at_thr = (kind == UPD_HIT || kind == UPD_TAKE) && (new_cnt == THR_W);
  end

  // next state of the table
  always_comb begin
    key_n   = key_q;
    cnt_n   = cnt_q;
    ovf_n   = ovf_q;
    vld_n   = vld_q;
    spill_n = spill_q;
    if (win_clr) begin
      key_n   = '0;
      cnt_n   = '0;
      ovf_n   = '0;
      vld_n   = '0;
      spill_n = '0;
    end else begin
      case (kind)
        UPD_HIT, UPD_TAKE: begin
          key_n[upd_idx] = stg_row_q;
          vld_n[upd_idx] = 1'b1;
          if (at_thr) begin
            cnt_n[upd_idx] = '0;
            ovf_n[upd_idx] = 1'b1;
          end else begin
            cnt_n[upd_idx] = new_cnt[CNT_W-1:0];
          end
        end
        UPD_SPILL: begin
          if (spill_q != SPILL_MAX) spill_n = spill_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // next state of the handshake stage and request register
  always_comb begin
    stg_vld_n = win_clr ? (stg_vld_q || accept) : accept;
    stg_row_n = accept ? act_row : stg_row_q;
    rf_vld_n  = at_thr;
    rf_row_n  = (kind != UPD_NONE) ? stg_row_q : rf_row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q     <= '0;
      cnt_q     <= '0;
      ovf_q     <= '0;
      vld_q     <= '0;
      spill_q   <= '0;
      stg_vld_q <= 1'b0;
      stg_row_q <= '0;
      rf_vld_q  <= 1'b0;
      rf_row_q  <= '0;
    end else begin
      key_q     <= key_n;
      cnt_q     <= cnt_n;
      ovf_q     <= ovf_n;
      vld_q     <= vld_n;
      spill_q   <= spill_n;
      stg_vld_q <= stg_vld_n;
      stg_row_q <= stg_row_n;
      rf_vld_q  <= rf_vld_n;
      rf_row_q  <= rf_row_n;
    end
  end

  assign rfsh_valid = rf_vld_q;
  assign rfsh_row   = rf_row_q;

  frt_victim_span #(.ROW_W(ROW_W), .RADIUS(RADIUS)) u_span (
    .row   (rf_row_q),
    .first (rfsh_first),
    .last  (rfsh_last)
  );

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !act_ready);

  // R9
  rfsh_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_valid |-> $past(stg_vld_q && !win_clr));

  // R1
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_clr |=> (spill_q == '0) && (vld_q == '0) && (ovf_q == '0));

  // R4
  spill_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_clr |=> spill_q >= $past(spill_q));

  // R8
  span_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_valid |-> (rfsh_first <= rfsh_row) && (rfsh_last >= rfsh_row));

  genvar e;
  generate
    for (e = 0; e < ENTRIES; e++) begin : g_pin
      // R6
      pinned_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q[e] && !win_clr) |=> ovf_q[e] && (key_q[e] == $past(key_q[e])));
    end
  endgenerate
endmodule

// File: tb/frow_tracker_test.sv
module frow_tracker_test;
  localparam int ROW_W   = 8;
  localparam int ENTRIES = 4;
  localparam int CNT_W   = 4;
  localparam int THRESH  = 5;
  localparam int RADIUS  = 2;
  localparam int ROW_MAX = (1 << ROW_W) - 1;
  localparam int SP_MAX  = (1 << CNT_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             win_clr;
  logic             act_valid;
  logic             act_ready;
  logic [ROW_W-1:0] act_row;
  logic             rfsh_valid;
  logic [ROW_W-1:0] rfsh_row;
  logic [ROW_W-1:0] rfsh_first;
  logic [ROW_W-1:0] rfsh_last;

  frow_tracker #(
    .ROW_W(ROW_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W), .THRESH(THRESH), .RADIUS(RADIUS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .win_clr(win_clr), .act_valid(act_valid),
    .act_ready(act_ready), .act_row(act_row), .rfsh_valid(rfsh_valid),
    .rfsh_row(rfsh_row), .rfsh_first(rfsh_first), .rfsh_last(rfsh_last)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  typedef struct {
    int     row;
    int     first;
    int     last;
    longint due;
    string  tag;
  } exp_t;
  exp_t sb[$];

  // reference model of the requirements
  int mk [ENTRIES];
  int mc [ENTRIES];
  bit mo [ENTRIES];
  bit mv [ENTRIES];
  int ms;

  function automatic void model_clear();
    for (int i = 0; i < ENTRIES; i++) begin
      mk[i] = 0; mc[i] = 0; mo[i] = 0; mv[i] = 0;
    end
    ms = 0;
  endfunction

  function automatic bit model_act(int row);
    int idx = -1;
    int nv  = 0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (mv[i] && mk[i] == row) idx = i;          // R2
    if (idx >= 0) nv = mc[idx] + 1;
    else begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!mo[i] && mc[i] == ms) idx = i;        // R3, R6, R7
      if (idx < 0) begin                          // R4
        if (ms < SP_MAX) ms = ms + 1;
        return 1'b0;
      end
      mk[idx] = row; mv[idx] = 1'b1; nv = ms + 1;
    end
    if (nv == THRESH) begin                       // R5
      mc[idx] = 0; mo[idx] = 1'b1;
      return 1'b1;
    end
    mc[idx] = nv;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic act(input int row, input bit clr, input string tag);
    exp_t e;
    @(negedge clk);
    while (!act_ready) @(negedge clk);
    act_valid = 1'b1;
    act_row   = ROW_W'(row);
    win_clr   = clr;
    if (clr) model_clear();                       // R10: clear first
    if (model_act(row)) begin
      e.row   = row;
      e.first = (row < RADIUS) ? 0 : row - RADIUS;          // R8
      e.last  = (row + RADIUS > ROW_MAX) ? ROW_MAX : row + RADIUS;
      e.due   = cyc + 2;                                    // R9
      e.tag   = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    act_valid = 1'b0;
    win_clr   = 1'b0;
    check(act_ready == 1'b0, "R9", "act_ready after accept", int'(act_ready), 0);
  endtask

  task automatic act_n(input int row, input int k, input string tag);
    for (int i = 0; i < k; i++) act(row, 1'b0, tag);
  endtask

  task automatic clear_window();
    @(negedge clk);
    win_clr = 1'b1;
    @(negedge clk);
    win_clr = 1'b0;
    model_clear();
  endtask

  // monitor: pops the scoreboard whenever a request appears
  always @(negedge clk) begin
    if (rst_n && rfsh_valid) begin
      exp_t e;
      if (sb.size() == 0) begin
        check(1'b0, "R5", "unexpected refresh row", int'(rfsh_row), -1);
      end else begin
        e = sb.pop_front();
        check(int'(rfsh_row) == e.row, e.tag, "refresh row", int'(rfsh_row), e.row);
        check(int'(rfsh_first) == e.first, "R8", "span first", int'(rfsh_first), e.first);
        check(int'(rfsh_last) == e.last, "R8", "span last", int'(rfsh_last), e.last);
        check(cyc == e.due, "R9", "refresh cycle", int'(cyc), int'(e.due));
      end
    end
  end

  initial begin
    win_clr = 1'b0; act_valid = 1'b0; act_row = '0;
    model_clear();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check(act_ready == 1'b1, "R1", "act_ready after reset", int'(act_ready), 1);
    check(rfsh_valid == 1'b0, "R1", "rfsh_valid after reset", int'(rfsh_valid), 0);

    // R2, R5: repeated hits fire at each multiple of the threshold
    act_n(8'h10, 10, "R5");
    act_n(8'h10, 4, "R2");                        // count 4: no request
    clear_window();

    // R8: span clamped at both ends of the row range
    act_n(8'h01, 5, "R8");
    act_n(8'hFE, 5, "R8");
    clear_window();

    // R3, R7: takeover keeps the spill count, lowest index taken
    act(8'h20, 1'b0, "R3"); act(8'h21, 1'b0, "R3");
    act(8'h22, 1'b0, "R3"); act(8'h23, 1'b0, "R3");
    act(8'h30, 1'b0, "R4");                       // spill -> 1
    act(8'h31, 1'b0, "R7");                       // takes entry 0, count 2
    act_n(8'h31, 3, "R3");                        // reaches 5
    act_n(8'h21, 4, "R7");                        // entry 1 kept its row
    clear_window();

    // R4: misses only raise the spill count
    for (int r = 8'h40; r < 8'h44; r++) act_n(r, 2, "R4");
    act(8'h50, 1'b0, "R4"); act(8'h51, 1'b0, "R4");
    act(8'h52, 1'b0, "R3");                       // takes entry 0 at count 3
    act_n(8'h52, 2, "R3");
    act_n(8'h41, 3, "R4");
    clear_window();

    // R6: an overflowed entry is never taken over
    act_n(8'h60, 5, "R6");
    act(8'h61, 1'b0, "R6"); act(8'h62, 1'b0, "R6"); act(8'h63, 1'b0, "R6");
    act(8'h70, 1'b0, "R6");
    act(8'h71, 1'b0, "R6");
    act_n(8'h60, 5, "R6");
    clear_window();

    // R1: after a clear the old row restarts from zero
    act_n(8'h60, 4, "R1");
    act(8'h60, 1'b0, "R1");
    clear_window();

    // R10: clear coinciding with an activation is applied first
    act_n(8'h80, 4, "R10");
    act(8'h80, 1'b1, "R10");
    act_n(8'h80, 4, "R10");

    repeat (6) @(negedge clk);
    check(sb.size() == 0, "R5", "missing refreshes", sb.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule